// File: doc/BRIEF.md
# Binary Counter with Run/Stop Enables and Start Override

This block is a free-running binary up-counter. It is meant for dividing a clock into several frequencies and for time-interval counting. The counter keeps a one-bit run/stop state. Two enable inputs, sampled on the clock, set that state. When exactly one of them is high at a rising edge, the counter stops. When both are high, it runs. When both are low, the state is left as it was.

A start input forces the counter to run and overrides the two enables. It clears a stopped state at once, with no wait for a clock edge. A master clear input returns the count to zero asynchronously, and the counter leaves the clear in the running state. Each count bit is driven as a true and complement pair. The count is a synchronous equivalent of a ripple chain, and its width is a parameter with a default of 8 bits.

Top module: `bcnt_dual_enable`

## Requirements
- R1: While the counter runs, each rising edge of `clk` raises `cnt_q` by exactly one.
- R2: The count wraps from all ones to all zeros, and no separate terminal-count output exists.
- R3: A rising edge with `force_run` low and exactly one of `sync_en_p`/`sync_en_q` high stops the counter. That edge does not change `cnt_q`, and the count then holds on every following edge until the counter is restarted.
- R4: A rising edge with `force_run` low and both enables low keeps the previous run/stop state. A stopped count stays unchanged and a running count keeps advancing.
- R5: A rising edge with both enables high puts the counter into the running state, and that same edge already increments `cnt_q`.
- R6: While `force_run` is high, the stopped state is cleared without waiting for a clock edge. The count then advances on every rising edge whatever the enables are.
- R7: While `master_clr` is high, `cnt_q` is zero at once, without waiting for a clock edge, and the counter is in the running state. `master_clr` takes priority over `force_run`, and the first edge after its release increments `cnt_q` unless an enable stops it.
- R8: `cnt_qn` is always the bitwise complement of `cnt_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; all synchronous actions occur on its rising edge |
| master_clr | input | 1 | Asynchronous active-high clear: count zero, state running |
| force_run | input | 1 | Asynchronous active-high start override; forces the running state |
| sync_en_p | input | 1 | First synchronous enable, combined with the second by exclusive-OR |
| sync_en_q | input | 1 | Second synchronous enable |
| cnt_q | output | WIDTH | Count value, true polarity |
| cnt_qn | output | WIDTH | Count value, complement polarity |

## Verification
A run/stop state that has gone wrong inside the block shows at the ports within one clock edge. A wrongly stopped counter fails to increment at the next edge, and a wrongly running one moves a count that should hold. Because the state is not visible directly, the bench puts it into a known value with enable pairs. It then exposes that value by idling the enables low and watching whether the count moves. The start override and the master clear act without a clock, so their effect is sampled between edges, before any clock could explain it.

// File: rtl/bcnt_pkg.sv
package bcnt_pkg;

    // Run/stop state of the counter
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_STOP = 1'b1
    } run_e;

    // Decoded control for one clock edge
    typedef struct packed {
        run_e next_state;
        logic step;
    } ctrl_t;

    // Next run/stop state from the enable pair and the override
    function automatic run_e next_run(input run_e cur, input logic en_p,
                                      input logic en_q, input logic force_hi);
        run_e r;
        if (force_hi)
            r = ST_RUN;
        else if (en_p && en_q)
            r = ST_RUN;
        else if (en_p ^ en_q)
            r = ST_STOP;
        else
            r = cur;
        return r;
    endfunction

endpackage

// File: rtl/bcnt_ctrl_decode.sv
module bcnt_ctrl_decode
    import bcnt_pkg::*;
(
    input  run_e  state_q,
    input  logic  en_p,
    input  logic  en_q,
    input  logic  force_hi,
    output ctrl_t ctrl
);
    always_comb begin
        ctrl.next_state = next_run(state_q, en_p, en_q, force_hi);
        // the edge that stops the counter does not advance it
        ctrl.step       = (ctrl.next_state == ST_RUN);
    end
endmodule

// File: rtl/bcnt_state_reg.sv
module bcnt_state_reg
    import bcnt_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic force_hi,
    input  run_e state_d,
    output run_e state_q
);
    always_ff @(posedge clk or posedge clr or posedge force_hi) begin
        if (clr)
            state_q <= ST_RUN;
        else if (force_hi)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/bcnt_count_reg.sv
module bcnt_count_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             step,
    output logic [WIDTH-1:0] count_q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            count_q <= '0;
        else if (step)
            count_q <= count_q + ONE;
    end
endmodule

// File: rtl/bcnt_out_pair.sv
module bcnt_out_pair #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] val,
    output logic [WIDTH-1:0] val_t,
    output logic [WIDTH-1:0] val_c
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign val_t[b] = val[b];
        assign val_c[b] = ~val[b];
    end
endmodule

// File: rtl/bcnt_dual_enable.sv
module bcnt_dual_enable
    import bcnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             master_clr,
    input  logic             force_run,
    input  logic             sync_en_p,
    input  logic             sync_en_q,
    output logic [WIDTH-1:0] cnt_q,
    output logic [WIDTH-1:0] cnt_qn
);
    run_e             state_q;
    ctrl_t            ctrl;
    logic [WIDTH-1:0] count_q;

    bcnt_ctrl_decode u_decode (
        .state_q  (state_q),
        .en_p     (sync_en_p),
        .en_q     (sync_en_q),
        .force_hi (force_run),
        .ctrl     (ctrl)
    );

    bcnt_state_reg u_state (
        .clk      (clk),
        .clr      (master_clr),
        .force_hi (force_run),
        .state_d  (ctrl.next_state),
        .state_q  (state_q)
    );

    bcnt_count_reg #(.WIDTH(WIDTH)) u_count (
        .clk     (clk),
        .clr     (master_clr),
        .step    (ctrl.step),
        .count_q (count_q)
    );

    bcnt_out_pair #(.WIDTH(WIDTH)) u_out (
        .val   (count_q),
        .val_t (cnt_q),
        .val_c (cnt_qn)
    );
endmodule

// File: rtl/bcnt_dual_enable_chk.sv
module bcnt_dual_enable_chk
    import bcnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             master_clr,
    input logic             force_run,
    input logic             sync_en_p,
    input logic             sync_en_q,
    input logic [WIDTH-1:0] cnt_q,
    input logic [WIDTH-1:0] cnt_qn,
    input run_e             state_q
);
    // R1 / R2 / R5: a running edge adds one, modulo 2**WIDTH
    p_step_r1: assert property (@(posedge clk) disable iff (master_clr)
        (force_run || (sync_en_p && sync_en_q) ||
         (!sync_en_p && !sync_en_q && state_q == ST_RUN))
        |=> cnt_q == WIDTH'($past(cnt_q) + WIDTH'(1)));

    // R3: a single enable stops the counter at that edge
    p_stop_r3: assert property (@(posedge clk) disable iff (master_clr)
        (!force_run && (sync_en_p ^ sync_en_q)) |=> $stable(cnt_q));

    // R4: idle enables keep a stopped counter stopped
    p_keep_r4: assert property (@(posedge clk) disable iff (master_clr)
        (!force_run && !sync_en_p && !sync_en_q && state_q == ST_STOP)
        |=> $stable(cnt_q));

    // R6: the override never coexists with a stopped state
    p_force_r6: assert property (@(posedge clk) disable iff (master_clr)
        force_run |-> state_q == ST_RUN);

    // R7: clear holds count at zero and the state at running
    p_clear_r7: assert property (@(posedge clk)
        master_clr |-> (cnt_q == '0 && state_q == ST_RUN));

    // R8: complement output pair
    p_pair_r8: assert property (@(posedge clk) disable iff (master_clr)
        cnt_qn == ~cnt_q);
endmodule

bind bcnt_dual_enable bcnt_dual_enable_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .master_clr (master_clr),
    .force_run  (force_run),
    .sync_en_p  (sync_en_p),
    .sync_en_q  (sync_en_q),
    .cnt_q      (cnt_q),
    .cnt_qn     (cnt_qn),
    .state_q    (state_q)
);

// File: tb/bcnt_dual_enable_tb_top.sv
module bcnt_dual_enable_tb_top;
    localparam int WIDTH = 8;
    localparam logic [WIDTH-1:0] ONES = '1;

    logic             clk = 1'b0;
    logic             master_clr = 1'b0;
    logic             force_run = 1'b0;
    logic             sync_en_p = 1'b0;
    logic             sync_en_q = 1'b0;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_qn;

    int checks = 0;
    int errors = 0;

    // reference model state: 1 means stopped
    logic             m_stop = 1'b0;
    logic [WIDTH-1:0] m_cnt = '0;

    always #5 clk = ~clk;

    bcnt_dual_enable #(.WIDTH(WIDTH)) dut_i (
        .clk        (clk),
        .master_clr (master_clr),
        .force_run  (force_run),
        .sync_en_p  (sync_en_p),
        .sync_en_q  (sync_en_q),
        .cnt_q      (cnt_q),
        .cnt_qn     (cnt_qn)
    );

    function automatic logic model_stop(input logic cur, input logic p,
                                        input logic q, input logic f);
        if (f) return 1'b0;
        if (p && q) return 1'b0;
        if (p ^ q) return 1'b1;
        return cur;
    endfunction

    task automatic check(input string req, input logic [WIDTH-1:0] exp);
        checks++;
        if (cnt_q !== exp) begin
            errors++;
            $display("FAIL %s cnt_q actual %0h expected %0h", req, cnt_q, exp);
        end
        checks++;
        if (cnt_qn !== ~exp) begin
            errors++;
            $display("FAIL R8 cnt_qn actual %0h expected %0h", cnt_qn, ~exp);
        end
    endtask

    // drive at negedge, let one rising edge pass, compare 2 ns later
    task automatic step(input logic p, input logic q, input logic f,
                        input logic c, input string req);
        @(negedge clk);
        sync_en_p  = p;
        sync_en_q  = q;
        force_run  = f;
        master_clr = c;
        @(posedge clk);
        if (c) begin
            m_cnt  = '0;
            m_stop = 1'b0;
        end else begin
            m_stop = model_stop(m_stop, p, q, f);
            if (!m_stop) m_cnt = m_cnt + WIDTH'(1);
        end
        #2;
        check(req, m_cnt);
    endtask

    initial begin : watchdog
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        #1 master_clr = 1'b1;
        #2;
        check("R7", '0);                       // reset state, before any edge
        step(1'b0, 1'b0, 1'b0, 1'b1, "R7");
        // R7: first edge after release increments
        step(1'b0, 1'b0, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R4");    // running stays running
        // R3: single enable stops at that edge, both polarities
        step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        // R5: both high restarts and counts on that edge
        step(1'b1, 1'b1, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R5");
        // R6: stop, then asynchronous override mid-cycle
        step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R6");    // override beats single enable
        step(1'b1, 1'b0, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R6");    // state left running
        // R7: asynchronous clear mid-cycle, seen before the next edge
        step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
        @(negedge clk);
        master_clr = 1'b1;
        force_run  = 1'b1;
        #1;
        m_cnt = '0;
        m_stop = 1'b0;
        check("R7", '0);
        step(1'b0, 1'b0, 1'b1, 1'b1, "R7");    // clear wins over override
        step(1'b0, 1'b0, 1'b0, 1'b0, "R7");
        // R2: wrap from all ones to zero
        while (m_cnt != ONES) step(1'b1, 1'b1, 1'b0, 1'b0, "R1");
        check("R2", ONES);
        step(1'b0, 1'b0, 1'b0, 1'b0, "R2");
        check("R2", '0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic p, q, f, c;
            p = 1'($urandom_range(0, 1));
            q = 1'($urandom_range(0, 1));
            f = ($urandom_range(0, 15) == 0);
            c = ($urandom_range(0, 63) == 0);
            step(p, q, f, c, "R1");
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule